// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 18-bit words. The producer side and the consumer side each have their own clock and enable. The two clocks may come from one source or may be fully unrelated. The depth is a power-of-two parameter from 256 to 4096 words.

The producer sees a full flag, a half-full flag and an almost-full flag. The consumer sees an empty flag and an almost-empty flag. Pointers cross between the two domains in Gray code. Each side computes its own flags from its own pointer and a synchronised copy of the other side's pointer.

The two threshold offsets start at 7 words after reset. While the configuration-load input is held high, each enabled write edge sends the data bus to the next offset register instead of to the storage array. The empty-side offset is loaded first, then the full-side offset, and the sequence then wraps.

Top module: `dualclk_pflag_fifo`

## Requirements
- R1: After an asynchronous reset (rstN low), emptyFlag and almostEmptyFlag are 1, fullFlag, halfFlag and almostFullFlag are 0, and both offsets hold 7.
- R2: With loadCfg low and the buffer not full, every rising wrClk edge with wrEn high stores wrData. Every rising rdClk edge with rdEn high and the buffer not empty places the oldest stored word on rdData. Words leave in the order they arrived.
- R3: A write while fullFlag is high is dropped. Nothing stored is overwritten, and exactly DEPTH words come back out.
- R4: A read while emptyFlag is high leaves rdData and the read position unchanged.
- R5: fullFlag is high when DEPTH words are held, and emptyFlag is high when none are held. Each flag may lag the opposite side's activity by the synchroniser delay, always in the safe direction.
- R6: halfFlag is high when the occupancy is above DEPTH/2. For DEPTH 256 it rises at 129 words.
- R7: almostEmptyFlag is high when the occupancy is less than or equal to the empty-side offset.
- R8: almostFullFlag is high when DEPTH minus the occupancy is less than or equal to the full-side offset.
- R9: While loadCfg is high, each wrEn edge copies wrData[log2(DEPTH)-1:0] into the next offset register. The empty-side offset is loaded first, then the full-side offset. The storage array and the write position are untouched.
- R10: The offset-load sequence keeps its position while loadCfg is low, and wraps from the full-side offset back to the empty-side offset. A reset restarts it at the empty-side offset.
- R11: Pointers cross clock domains in Gray code, changing one bit per step. Data stays intact when wrClk and rdClk are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Producer clock |
| rdClk | input | 1 | Consumer clock |
| rstN | input | 1 | Asynchronous reset, active low, shared by both domains |
| wrEn | input | 1 | Write enable, sampled on wrClk |
| loadCfg | input | 1 | Sends enabled writes to the offset registers instead of the array |
| wrData | input | 18 | Word to store, or offset value while loadCfg is high |
| rdEn | input | 1 | Read enable, sampled on rdClk |
| rdData | output | 18 | Registered output word |
| emptyFlag | output | 1 | No words held (consumer domain) |
| almostEmptyFlag | output | 1 | Occupancy at or below the empty-side offset (consumer domain) |
| fullFlag | output | 1 | DEPTH words held (producer domain) |
| halfFlag | output | 1 | Occupancy above DEPTH/2 (producer domain) |
| almostFullFlag | output | 1 | Free space at or below the full-side offset (producer domain) |

## Verification
The bench probes each threshold on both sides of its edge: 7 and 8 words, 128 and 129, 248 and 249, 255 and 256. An off-by-one in any comparison therefore flips exactly one check. Extra writes are pushed while the buffer is full, and the whole buffer is then drained. A design that lets the write pointer lap the read pointer returns corrupted or extra words. Offsets are loaded with junk in the upper data bits, the sequence is wrapped, it is paused with loadCfg low, and it is then reset mid-way. A sequencer that loses its position, stores offset words in the array, or fails to restart shows up as a flag edge at the wrong occupancy.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

  localparam int unsigned DATA_W         = 18;
  localparam int unsigned DEFAULT_OFFSET = 7;

  // Strobes from the control block to the datapath, write domain
  typedef struct packed {
    logic memWrite;
    logic loadEmptyOff;
    logic loadFullOff;
  } wr_strobe_t;

  // Strobes from the control block to the datapath, read domain
  typedef struct packed {
    logic memRead;
  } rd_strobe_t;

  // Position of the offset-load sequencer
  typedef enum logic {
    SEQ_EMPTY_OFF = 1'b0,
    SEQ_FULL_OFF  = 1'b1
  } load_seq_t;

endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import pfifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(DEPTH),
  localparam int unsigned PTR_W      = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              loadCfg,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] emptyOff,
  input  logic [ADDR_W-1:0] fullOff,
  output wr_strobe_t        wrStb,
  output rd_strobe_t        rdStb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyFlag,
  output logic              almostEmptyFlag,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              almostFullFlag
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

  function automatic logic [PTR_W-1:0] binToGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext;
  logic [PTR_W-1:0] rdGraySyncW, rdBinSyncW;
  logic [PTR_W-1:0] wrOcc, wrFree;
  logic             wrAccept;
  logic             cfgWrite;
  load_seq_t        seqState;

  assign rdBinSyncW = grayToBin(rdGraySyncW);
  assign wrOcc      = wrBin - rdBinSyncW;
  assign wrFree     = DEPTH_P - wrOcc;
  assign fullFlag   = (wrOcc == DEPTH_P);
  assign halfFlag   = (wrOcc > HALF_P);
  assign almostFullFlag = (wrFree <= {1'b0, fullOff});

  assign cfgWrite  = wrEn & loadCfg;
  assign wrAccept  = wrEn & ~loadCfg & ~fullFlag;
  assign wrBinNext = wrBin + ONE_P;
  assign wrAddr    = wrBin[ADDR_W-1:0];

  always_comb begin
    wrStb              = '0;
    wrStb.memWrite     = wrAccept;
    wrStb.loadEmptyOff = cfgWrite & (seqState == SEQ_EMPTY_OFF);
    wrStb.loadFullOff  = cfgWrite & (seqState == SEQ_FULL_OFF);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrAccept) begin
      wrBin  <= wrBinNext;
      wrGray <= binToGray(wrBinNext);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_EMPTY_OFF;
    end else if (cfgWrite) begin
      seqState <= (seqState == SEQ_EMPTY_OFF) ? SEQ_FULL_OFF : SEQ_EMPTY_OFF;
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext;
  logic [PTR_W-1:0] wrGraySyncR, wrBinSyncR;
  logic [PTR_W-1:0] rdOcc;
  logic             rdAccept;

  assign wrBinSyncR      = grayToBin(wrGraySyncR);
  assign rdOcc           = wrBinSyncR - rdBin;
  assign emptyFlag       = (rdOcc == '0);
  assign almostEmptyFlag = (rdOcc <= {1'b0, emptyOff});
  assign rdAccept        = rdEn & ~emptyFlag;
  assign rdBinNext       = rdBin + ONE_P;
  assign rdAddr          = rdBin[ADDR_W-1:0];
  assign rdStb.memRead   = rdAccept;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdAccept) begin
      rdBin  <= rdBinNext;
      rdGray <= binToGray(rdBinNext);
    end
  end

  // ---------------- pointer crossings ----------------
  pfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk (wrClk),
    .rstN(rstN),
    .din (rdGray),
    .dout(rdGraySyncW)
  );

  pfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk (rdClk),
    .rstN(rstN),
    .din (wrGray),
    .dout(wrGraySyncR)
  );

  // ---------------- assertions ----------------
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    (fullFlag && wrEn) |=> $stable(wrBin));

  assert_no_underflow_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && rdEn) |=> $stable(rdBin));

  assert_occ_bound_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    wrOcc <= DEPTH_P);

  assert_full_implies_upper_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> (halfFlag && almostFullFlag));

  assert_empty_implies_ae_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> almostEmptyFlag);

  assert_load_keeps_ptr_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    (loadCfg && wrEn) |=> $stable(wrBin));

  assert_wr_gray_step_R11: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  assert_rd_gray_step_R11: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

endmodule

// File: rtl/pfifo_data.sv
module pfifo_data
  import pfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  wr_strobe_t        wrStb,
  input  rd_strobe_t        rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] emptyOff,
  output logic [ADDR_W-1:0] fullOff
);

  localparam logic [ADDR_W-1:0] DEF_OFF = ADDR_W'(DEFAULT_OFFSET);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrStb.memWrite) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdStb.memRead) begin
      rdData <= mem[rdAddr];
    end
  end

  // Threshold registers; only the low address-width bits of the bus are kept
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOff <= DEF_OFF;
      fullOff  <= DEF_OFF;
    end else begin
      if (wrStb.loadEmptyOff) emptyOff <= wrData[ADDR_W-1:0];
      if (wrStb.loadFullOff)  fullOff  <= wrData[ADDR_W-1:0];
    end
  end

  assert_strobe_exclusive_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({wrStb.memWrite, wrStb.loadEmptyOff, wrStb.loadFullOff}));

  assert_empty_off_load_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    wrStb.loadEmptyOff |=> (emptyOff == $past(wrData[ADDR_W-1:0])));

  assert_full_off_hold_R10: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrStb.loadFullOff |=> $stable(fullOff));

endmodule

// File: rtl/dualclk_pflag_fifo.sv
module dualclk_pflag_fifo
  import pfifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              loadCfg,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              almostEmptyFlag,
  output logic              fullFlag,
  output logic              halfFlag,
  output logic              almostFullFlag
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  wr_strobe_t        wrStb;
  rd_strobe_t        rdStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ADDR_W-1:0] emptyOff, fullOff;

  pfifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk          (wrClk),
    .rdClk          (rdClk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .loadCfg        (loadCfg),
    .rdEn           (rdEn),
    .emptyOff       (emptyOff),
    .fullOff        (fullOff),
    .wrStb          (wrStb),
    .rdStb          (rdStb),
    .wrAddr         (wrAddr),
    .rdAddr         (rdAddr),
    .emptyFlag      (emptyFlag),
    .almostEmptyFlag(almostEmptyFlag),
    .fullFlag       (fullFlag),
    .halfFlag       (halfFlag),
    .almostFullFlag (almostFullFlag)
  );

  pfifo_data #(.DEPTH(DEPTH)) u_data (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .emptyOff(emptyOff),
    .fullOff (fullOff)
  );

  assert_empty_read_hold_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && rdEn) |=> $stable(rdData));

endmodule

// File: tb/dualclk_pflag_fifo_test.sv
module dualclk_pflag_fifo_test;

  localparam int DEPTH = 256;

  logic        wrClk = 1'b0;
  logic        rdClk = 1'b0;
  logic        rstN  = 1'b0;
  logic        wrEn  = 1'b0;
  logic        loadCfg = 1'b0;
  logic [17:0] wrData = '0;
  logic        rdEn  = 1'b0;
  logic [17:0] rdData;
  logic        emptyFlag, almostEmptyFlag, fullFlag, halfFlag, almostFullFlag;

  int checks = 0;
  int fails  = 0;
  logic [17:0] nextVal = 18'h2_0000;
  logic [17:0] model[$];

  dualclk_pflag_fifo #(.DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .loadCfg(loadCfg),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .emptyFlag(emptyFlag),
    .almostEmptyFlag(almostEmptyFlag), .fullFlag(fullFlag), .halfFlag(halfFlag),
    .almostFullFlag(almostFullFlag)
  );

  always #10 wrClk = ~wrClk;   // 50 MHz
  always #13 rdClk = ~rdClk;   // unrelated consumer clock

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wrClk);
    repeat (5) @(negedge rdClk);
  endtask

  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrData = nextVal;
      if (model.size() < DEPTH) model.push_back(nextVal);
      nextVal++;
    end
    @(negedge wrClk);
    wrEn = 1'b0;
    settle();
  endtask

  task automatic loadOffsets(input int vals[$]);
    foreach (vals[i]) begin
      @(negedge wrClk);
      loadCfg = 1'b1; wrEn = 1'b1;
      wrData = 18'h3_FF00 | 18'(vals[i]);   // upper bits must be ignored
    end
    @(negedge wrClk);
    loadCfg = 1'b0; wrEn = 1'b0;
    settle();
  endtask

  task automatic drainCheck(input int n, input string req);
    @(negedge rdClk);
    rdEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [17:0] exp;
      @(negedge rdClk);
      if (i == n - 1) rdEn = 1'b0;
      exp = model.pop_front();
      check(rdData == exp, req, "read order", int'(rdData), int'(exp));
    end
    settle();
  endtask

  task automatic doReset();
    @(negedge wrClk);
    rstN = 1'b0;
    repeat (2) @(negedge wrClk);
    rstN = 1'b1;
    model.delete();
    settle();
  endtask

  task automatic t_reset();
    doReset();
    check(emptyFlag == 1, "R1", "empty", emptyFlag, 1);
    check(almostEmptyFlag == 1, "R1", "almostEmpty", almostEmptyFlag, 1);
    check(fullFlag == 0, "R1", "full", fullFlag, 0);
    check(halfFlag == 0, "R1", "half", halfFlag, 0);
    check(almostFullFlag == 0, "R1", "almostFull", almostFullFlag, 0);
  endtask

  task automatic t_order();
    pushWords(5);
    check(emptyFlag == 0, "R2", "not empty after writes", emptyFlag, 0);
    drainCheck(5, "R2 R11");
    check(emptyFlag == 1, "R5", "empty after drain", emptyFlag, 1);
  endtask

  task automatic t_readEmpty();
    logic [17:0] held;
    held = rdData;
    repeat (3) begin
      @(negedge rdClk); rdEn = 1'b1;
      @(negedge rdClk); rdEn = 1'b0;
    end
    check(rdData == held, "R4", "rdData held on empty read", int'(rdData), int'(held));
    check(emptyFlag == 1, "R4", "still empty", emptyFlag, 1);
    pushWords(1);
    drainCheck(1, "R4");   // read position did not move
  endtask

  task automatic t_thresholds();
    pushWords(7);
    check(almostEmptyFlag == 1, "R7", "ae at 7", almostEmptyFlag, 1);
    pushWords(1);
    check(almostEmptyFlag == 0, "R7", "ae at 8", almostEmptyFlag, 0);
    pushWords(120);
    check(halfFlag == 0, "R6", "half at 128", halfFlag, 0);
    pushWords(1);
    check(halfFlag == 1, "R6", "half at 129", halfFlag, 1);
    pushWords(119);
    check(almostFullFlag == 0, "R8", "af at 248", almostFullFlag, 0);
    pushWords(1);
    check(almostFullFlag == 1, "R8", "af at 249", almostFullFlag, 1);
    pushWords(6);
    check(fullFlag == 0, "R5", "full at 255", fullFlag, 0);
    pushWords(1);
    check(fullFlag == 1, "R5", "full at 256", fullFlag, 1);
    check(emptyFlag == 0, "R5", "empty at 256", emptyFlag, 0);
  endtask

  task automatic t_overflow();
    pushWords(4);   // dropped
    check(fullFlag == 1, "R3", "full after extra writes", fullFlag, 1);
    check(model.size() == DEPTH, "R3", "model size", model.size(), DEPTH);
    drainCheck(DEPTH, "R3");
    check(emptyFlag == 1, "R3", "empty after full drain", emptyFlag, 1);
  endtask

  task automatic t_load();
    loadOffsets('{3, 10});
    check(emptyFlag == 1, "R9", "offset words not stored", emptyFlag, 1);
    pushWords(3);
    check(almostEmptyFlag == 1, "R9", "ae at 3 with offset 3", almostEmptyFlag, 1);
    pushWords(1);
    check(almostEmptyFlag == 0, "R9", "ae at 4 with offset 3", almostEmptyFlag, 0);
    pushWords(241);
    check(almostFullFlag == 0, "R9", "af at 245 with offset 10", almostFullFlag, 0);
    pushWords(1);
    check(almostFullFlag == 1, "R9", "af at 246 with offset 10", almostFullFlag, 1);
    drainCheck(246, "R9");
  endtask

  task automatic t_wrap();
    loadOffsets('{2, 20, 5});   // third word wraps to the empty-side offset
    pushWords(5);
    check(almostEmptyFlag == 1, "R10", "ae at 5 after wrap", almostEmptyFlag, 1);
    pushWords(1);
    check(almostEmptyFlag == 0, "R10", "ae at 6 after wrap", almostEmptyFlag, 0);
    drainCheck(6, "R10");
    loadOffsets('{30});         // sequence resumes at the full-side offset
    pushWords(225);
    check(almostFullFlag == 0, "R10", "af at 225 offset 30", almostFullFlag, 0);
    pushWords(1);
    check(almostFullFlag == 1, "R10", "af at 226 offset 30", almostFullFlag, 1);
    check(almostEmptyFlag == 0, "R10", "ae at 226", almostEmptyFlag, 0);
    drainCheck(226, "R10");
    doReset();
    loadOffsets('{1});          // must land in the empty-side offset again
    pushWords(1);
    check(almostEmptyFlag == 1, "R10", "ae at 1 after reset load", almostEmptyFlag, 1);
    pushWords(1);
    check(almostEmptyFlag == 0, "R10", "ae at 2 after reset load", almostEmptyFlag, 0);
    drainCheck(2, "R10");
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    t_reset();
    t_order();
    t_readEmpty();
    t_thresholds();
    t_overflow();
    t_load();
    t_wrap();
    finish();
  end

endmodule